// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block collects interrupt requests from a parameterised number of external pins (two by default) and one serial-receive source, and presents them to a processor as a single request line. Each external pin goes through a synchronizer. A per-pin mode bit selects how the pin is used. In edge-triggered mode a rising edge sets a sticky request flag. In level-sensitive mode the synchronized pin level is the request, with no storage in between. A write strobe with an 8-bit code clears individual pin flags. The serial-receive flag is set by a pulse from the receiver and cleared only by a receive-buffer read strobe or by reset.

The processor answers a request with a one-cycle acknowledge. In the next cycle the block presents a 16-bit vector code for the highest-priority pending source. In that same cycle the flag of the granted source is cleared if that source is an edge-mode pin. The acknowledged source may lose its request in the acknowledge cycle, or nothing may be pending at all. In either case the block returns a fixed "cleared" code in place of a source code.

Top module: `irq_latch_ctrl`

## Requirements
- R1: While reset is held, and in the cycle after it, `irq_out` and `vec_valid` are 0 and every pin is in edge-triggered mode (mode bit 0).
- R2: In edge-triggered mode, a rising edge on a pin sets that pin's request flag. The edge reaches the flag three clock edges after the input changes. The request stays set after the pin returns low.
- R3: In level-sensitive mode (mode bit 1), a pin's request is its synchronized level, two clock edges behind the pin. The request rises and falls with the pin.
- R4: Writing a mode bit from 0 to 1 clears the pin's stored flag. If the pin is low, the request is 0 after the switch and stays 0 after switching back to edge mode.
- R5: Writing a mode bit from 1 to 0 keeps a flag stored while the pin was high in level mode. The request stays set until the clear port clears it.
- R6: A clear-port write (`clr_wr`=1) with `clr_data`=0x0A clears pin 0 and 0x0B clears pin 1; any other value leaves all flags unchanged.
- R7: The serial-receive flag is set by `rx_set` and is cleared only by `rx_buf_rd` or by reset. Clear-port writes of any value do not affect it.
- R8: One cycle after `ack`, `vec_valid` is 1 for exactly one cycle. `vec_code` then holds the code of the highest-priority source that was pending in the ack cycle. Priority is pin 0 > pin 1 > serial receive, with codes 0x000A, 0x000B and 0x000C.
- R9: An acknowledge clears the granted source's flag only when that source is an edge-mode pin. A level-mode pin and the serial-receive flag stay pending after an acknowledge.
- R10: The vector is 0x0008 in two cases: nothing is pending in the ack cycle, or the granted source is cleared in that same cycle (a clear-port write for an edge-mode pin, or `rx_buf_rd` for the serial source).
- R11: `irq_out` is 1 exactly when at least one source has a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | NUM_PINS | Asynchronous external interrupt pins |
| mode_wr | input | 1 | Mode register write strobe |
| mode_data | input | NUM_PINS | New mode bits, 1 = level-sensitive, 0 = edge-triggered |
| clr_wr | input | 1 | Clear-port write strobe |
| clr_data | input | 8 | Clear code (0x0A + pin index) |
| rx_set | input | 1 | Serial receiver data-ready pulse |
| rx_buf_rd | input | 1 | Receive-buffer read strobe |
| ack | input | 1 | One-cycle interrupt acknowledge |
| irq_out | output | 1 | Combined interrupt request |
| vec_valid | output | 1 | Vector code valid, one cycle after ack |
| vec_code | output | 16 | Vector code of the acknowledged source |

## Verification
The properties assume that `rst` is high from the first clock edge, that `ack` lasts a single cycle, and that every input changes only away from the rising clock edge. The bench drives all inputs on the falling edge and holds each pin level for at least two clocks, so every level and edge reaches the synchronizer. The clear-code property relies on no new edge arriving on pin 0 in the cycle of the write. The table-driven clear tests therefore let the pin settle low before each write.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    localparam logic [15:0] VEC_CLEARED = 16'h0008;
    localparam logic [15:0] VEC_BASE    = 16'h000A;
    localparam logic [7:0]  CLR_BASE    = 8'h0A;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

    function automatic logic [15:0] src_vector(input int idx);
        return VEC_BASE + 16'(idx);
    endfunction

    function automatic logic [7:0] clr_code(input int idx);
        return CLR_BASE + 8'(idx);
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic rise
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], pin};
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/irq_pin_flag.sv
module irq_pin_flag
    import irq_latch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  trig_mode_e mode,
    input  logic       mode_wr,
    input  trig_mode_e mode_next,
    input  logic       level,
    input  logic       rise,
    input  logic       clr_hit,
    input  logic       ack_clr,
    output logic       req
);
    logic flag_q;
    logic to_level;

    assign to_level = mode_wr && (mode == TRIG_EDGE) && (mode_next == TRIG_LEVEL);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (to_level) begin
            // Entering level mode drops any stored edge request
            flag_q <= 1'b0;
        end else if (mode == TRIG_LEVEL) begin
            // High level holds the flop set; the acknowledge never clears it
            flag_q <= level | (flag_q & ~clr_hit);
        end else begin
            // A new edge wins over a clear in the same cycle
            flag_q <= rise | (flag_q & ~(clr_hit | ack_clr));
        end
    end

    assign req = (mode == TRIG_LEVEL) ? level : flag_q;
endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit
    import irq_latch_pkg::*;
#(
    parameter int NSRC = 3,
    parameter int NCLR = 2,
    localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] pending,
    input  logic [NSRC-1:0] kill,
    input  logic            ack,
    output logic [NCLR-1:0] ack_clr,
    output logic            vec_valid,
    output logic [15:0]     vec_code
);
    logic          found;
    logic [IW-1:0] win_idx;
    logic          survive;

    // Lowest index wins: scan from the top so lower indices overwrite
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pending[i]) begin
                found   = 1'b1;
                win_idx = IW'(i);
            end
        end
    end

    assign survive = found && !kill[win_idx];

    always_comb begin
        for (int i = 0; i < NCLR; i++) begin
            ack_clr[i] = ack && found && (win_idx == IW'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_valid <= 1'b0;
            vec_code  <= '0;
        end else begin
            vec_valid <= ack;
            if (ack) vec_code <= survive ? src_vector(int'(win_idx)) : VEC_CLEARED;
        end
    end
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
    import irq_latch_pkg::*;
#(
    parameter int NUM_PINS    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] ext_pin,
    input  logic                mode_wr,
    input  logic [NUM_PINS-1:0] mode_data,
    input  logic                clr_wr,
    input  logic [7:0]          clr_data,
    input  logic                rx_set,
    input  logic                rx_buf_rd,
    input  logic                ack,
    output logic                irq_out,
    output logic                vec_valid,
    output logic [15:0]         vec_code
);
    localparam int NSRC = NUM_PINS + 1;

    logic [NUM_PINS-1:0] mode_q;
    logic [NUM_PINS-1:0] pin_level;
    logic [NUM_PINS-1:0] pin_rise;
    logic [NUM_PINS-1:0] pin_req;
    logic [NUM_PINS-1:0] clr_hit;
    logic [NUM_PINS-1:0] ack_clr;
    logic [NSRC-1:0]     pending;
    logic [NSRC-1:0]     kill;
    logic                rx_flag;

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= '0;
        else if (mode_wr) mode_q <= mode_data;
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        irq_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk   (clk),
            .rst   (rst),
            .pin   (ext_pin[g]),
            .level (pin_level[g]),
            .rise  (pin_rise[g])
        );

        assign clr_hit[g] = clr_wr && (clr_data == clr_code(g));

        irq_pin_flag flag_i (
            .clk       (clk),
            .rst       (rst),
            .mode      (trig_mode_e'(mode_q[g])),
            .mode_wr   (mode_wr),
            .mode_next (trig_mode_e'(mode_data[g])),
            .level     (pin_level[g]),
            .rise      (pin_rise[g]),
            .clr_hit   (clr_hit[g]),
            .ack_clr   (ack_clr[g]),
            .req       (pin_req[g])
        );

        // Only a stored edge flag can vanish through the clear port
        assign kill[g] = clr_hit[g] & ~mode_q[g];
    end

    // Serial receive flag: buffer read or reset only; a new pulse wins
    always_ff @(posedge clk) begin
        if (rst) rx_flag <= 1'b0;
        else     rx_flag <= rx_set | (rx_flag & ~rx_buf_rd);
    end

    assign pending  = {rx_flag, pin_req};
    assign kill[NUM_PINS] = rx_buf_rd;
    assign irq_out  = |pending;

    irq_vec_unit #(.NSRC(NSRC), .NCLR(NUM_PINS)) vec_i (
        .clk       (clk),
        .rst       (rst),
        .pending   (pending),
        .kill      (kill),
        .ack       (ack),
        .ack_clr   (ack_clr),
        .vec_valid (vec_valid),
        .vec_code  (vec_code)
    );
endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk (
    input logic        clk,
    input logic        rst,
    input logic        ack,
    input logic        irq_out,
    input logic        vec_valid,
    input logic [15:0] vec_code,
    input logic        clr_wr,
    input logic [7:0]  clr_data,
    input logic        rx_buf_rd,
    input logic        rx_q,
    input logic        mode0,
    input logic        rise0,
    input logic        req0
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!irq_out && !vec_valid));

    // R8
    vec_after_ack_chk: assert property (@(posedge clk) disable iff (rst) ack |=> vec_valid);

    // R8
    vec_only_after_ack_chk: assert property (@(posedge clk) disable iff (rst) !ack |=> !vec_valid);

    // R10
    empty_ack_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !irq_out) |=> (vec_code == 16'h0008));

    // R7
    rx_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_q && !rx_buf_rd) |=> rx_q);

    // R6
    pin0_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode0 && clr_wr && (clr_data == 8'h0A) && !rise0) |=> !req0);
endmodule

bind irq_latch_ctrl irq_latch_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .ack       (ack),
    .irq_out   (irq_out),
    .vec_valid (vec_valid),
    .vec_code  (vec_code),
    .clr_wr    (clr_wr),
    .clr_data  (clr_data),
    .rx_buf_rd (rx_buf_rd),
    .rx_q      (rx_flag),
    .mode0     (mode_q[0]),
    .rise0     (pin_rise[0]),
    .req0      (pin_req[0])
);

// File: tb/irq_latch_ctrl_tb.sv
module irq_latch_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  ext_pin = '0;
    logic        mode_wr = 1'b0;
    logic [1:0]  mode_data = '0;
    logic        clr_wr = 1'b0;
    logic [7:0]  clr_data = '0;
    logic        rx_set = 1'b0;
    logic        rx_buf_rd = 1'b0;
    logic        ack = 1'b0;
    logic        irq_out;
    logic        vec_valid;
    logic [15:0] vec_code;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_latch_ctrl dut_i (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .mode_wr(mode_wr),
        .mode_data(mode_data), .clr_wr(clr_wr), .clr_data(clr_data),
        .rx_set(rx_set), .rx_buf_rd(rx_buf_rd), .ack(ack),
        .irq_out(irq_out), .vec_valid(vec_valid), .vec_code(vec_code)
    );

    // {clear code, expected irq_out with only pin 0 flagged} for R6
    localparam logic [8:0] CLR_TAB [6] = '{
        {8'h0B, 1'b1}, {8'h00, 1'b1}, {8'hFF, 1'b1},
        {8'h0C, 1'b1}, {8'h8A, 1'b1}, {8'h0A, 1'b0}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        chk(irq_out === exp, tag, 16'(irq_out), 16'(exp));
    endtask

    task automatic pulse_pins(input logic [1:0] p);
        ext_pin = p; step(2);
        ext_pin = '0; step(3);
    endtask

    task automatic write_clr(input logic [7:0] d);
        clr_wr = 1'b1; clr_data = d; step(1);
        clr_wr = 1'b0;
    endtask

    task automatic write_mode(input logic [1:0] m);
        mode_wr = 1'b1; mode_data = m; step(1);
        mode_wr = 1'b0;
    endtask

    task automatic do_ack(input string tag, input logic [15:0] exp);
        ack = 1'b1; step(1);
        ack = 1'b0;
        chk(vec_valid === 1'b1, tag, 16'(vec_valid), 16'h1);
        chk(vec_code === exp, tag, vec_code, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        step(3);
        chk_irq("R1 reset irq", 1'b0);
        chk(vec_valid === 1'b0, "R1 reset vec_valid", 16'(vec_valid), 16'h0);
        rst = 1'b0;
        step(1);
        chk_irq("R1 after reset", 1'b0);

        // R2: sticky edge flag
        pulse_pins(2'b01);
        chk_irq("R2 edge sticky", 1'b1);

        // R6: table of clear codes
        for (int i = 0; i < 6; i++) begin
            pulse_pins(2'b01);
            write_clr(CLR_TAB[i][8:1]);
            chk_irq($sformatf("R6 clear code %h", CLR_TAB[i][8:1]), CLR_TAB[i][0]);
        end

        // R8/R9: priority and acknowledge clearing
        rx_set = 1'b1; step(1); rx_set = 1'b0;
        chk_irq("R11 rx only", 1'b1);
        pulse_pins(2'b11);
        do_ack("R8 pin0 first", 16'h000A);
        chk_irq("R9 others pending", 1'b1);
        step(1);
        chk(vec_valid === 1'b0, "R8 single cycle", 16'(vec_valid), 16'h0);
        do_ack("R8 pin1 second", 16'h000B);
        do_ack("R8 rx third", 16'h000C);
        do_ack("R9 rx not cleared by ack", 16'h000C);
        write_clr(8'h0C);
        write_clr(8'h0A);
        chk_irq("R7 clear port ignored by rx", 1'b1);
        rx_buf_rd = 1'b1; step(1); rx_buf_rd = 1'b0;
        chk_irq("R7 buffer read clears", 1'b0);

        // R10: late clear and empty acknowledge
        pulse_pins(2'b10);
        chk_irq("R11 pin1 only", 1'b1);
        ack = 1'b1; clr_wr = 1'b1; clr_data = 8'h0B; step(1);
        ack = 1'b0; clr_wr = 1'b0;
        chk(vec_code === 16'h0008, "R10 late clear", vec_code, 16'h0008);
        chk_irq("R10 flag gone", 1'b0);
        do_ack("R10 nothing pending", 16'h0008);

        // R3: level mode on pin 0
        write_mode(2'b01);
        chk_irq("R3 level low", 1'b0);
        ext_pin = 2'b01; step(2);
        chk_irq("R3 level high", 1'b1);
        do_ack("R3 level vector", 16'h000A);
        step(1);
        chk_irq("R9 level not cleared by ack", 1'b1);
        ext_pin = 2'b00; step(2);
        chk_irq("R3 level follows low", 1'b0);

        // R5: level to edge keeps the accepted request
        write_mode(2'b00);
        chk_irq("R5 kept after switch", 1'b1);
        write_clr(8'h0A);
        chk_irq("R5 cleared by port", 1'b0);

        // R4: edge to level drops stored flag
        pulse_pins(2'b01);
        chk_irq("R4 stored edge", 1'b1);
        write_mode(2'b01);
        chk_irq("R4 cleared on switch", 1'b0);
        write_mode(2'b00);
        chk_irq("R4 stays cleared", 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule